// File: doc/BRIEF.md
# Chunked SPI Command Transaction Engine

This block is the master side of a framed SPI link. A client hands it one request: direction, a 17-bit start address, a byte count and a flag that pins the address. The engine cuts the request into chunks no longer than `MAX_CHUNK` bytes. Every chunk begins with its own 32-bit command word, and the block then moves the data bytes. Write bytes come from a valid/ready input stream. Read bytes leave on a valid/ready output stream.

Before a read chunk takes any data, the engine checks that the target is ready. It clocks in a block of status words right after the command. If the target is not ready, it polls with one word per chip-select frame, up to a bounded number of attempts. When the retries run out, the chunk is flagged as failed and its data is replaced by zeros, so the consumer still gets the byte count it asked for.

Back-pressure works byte by byte. A write byte is taken only when it is offered. A read byte stays held until the consumer accepts it, and the serial clock pauses while the engine waits in either direction. Chip select stays low during such a pause.

Top module: `spi_chunk_engine`

## Requirements
- R1: Each chunk's frame opens with a 32-bit command word, sent MSB first. Bit 31 is 0, bit 30 is 1 for a read, bit 29 is the fixed-address flag, bits 28:17 hold the chunk byte count and bits 16:0 hold the chunk address. The bus uses SPI mode 0: SCLK idles low, MOSI is stable at the rising edge and MISO is sampled on it.
- R2: A request of L bytes is sent as ceil(L / MAX_CHUNK) chunks. Every chunk is MAX_CHUNK bytes except the last, which carries the remainder.
- R3: Without the fixed flag, each chunk's address is the previous chunk's address plus its byte count, modulo 2^17. With the flag, every chunk carries the request address.
- R4: A write chunk sends its data bytes MSB first in the same chip-select frame as its command. The bytes are taken in order from the write stream, one per handshake.
- R5: A read chunk clocks in BUSY_WORDS 32-bit words in the command frame. If bit 0 of the last of these is 1, a separate data frame follows, and the bytes received go out in order on the read stream.
- R6: If that bit is 0, the engine polls. Each poll is one 32-bit word in its own chip-select frame. Polling stops at the first word whose bit 0 is 1, and there are never more than BUSY_RETRY polls per chunk.
- R7: When BUSY_RETRY polls all read 0, the engine delivers that chunk's byte count as zero bytes and moves on to the next chunk. The request then ends with done_err high.
- R8: rd_tdata holds steady while rd_tvalid is high and rd_tready is low. wr_tready is never high without wr_tvalid.
- R9: req_ready is high only while idle. After a request is taken it stays low until the one-cycle done pulse. A zero-length request completes with no chip-select activity.
- R10: SCLK is low whenever chip select is high, and after reset chip select is high and SCLK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken when both are high |
| req_read | input | 1 | 1 = read, 0 = write |
| req_fixed | input | 1 | Keep the same address for all chunks |
| req_addr | input | 17 | Start byte address |
| req_len | input | LEN_W | Total byte count |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | With done: a read chunk timed out |
| wr_tdata | input | 8 | Write byte |
| wr_tvalid | input | 1 | Write byte valid |
| wr_tready | output | 1 | Write byte taken |
| rd_tdata | output | 8 | Read byte |
| rd_tvalid | output | 1 | Read byte valid |
| rd_tready | input | 1 | Consumer accepts read byte |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Master data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Two events can land on the same word: the last permitted poll comes back ready, and the retry counter reaches its limit. The ready result must win, and that chunk must deliver real data. The bench provokes this by making the modelled target answer ready on exactly poll number BUSY_RETRY, and then on poll BUSY_RETRY+1. In the first case the chunk must complete with target data, BUSY_RETRY polls and a clean done. In the second case it must deliver zero bytes, the same poll count and done_err.

// File: rtl/spice_pkg.sv
package spice_pkg;
  localparam int ADDR_W = 17;
  localparam int CLEN_W = 12;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_BUSY, S_GAP, S_POLL,
    S_WDATA, S_RDATA, S_RHOLD, S_ZERO, S_DONE
  } eng_state_t;

  function automatic logic [31:0] pack_cmd(input logic rd, input logic fixed,
                                           input logic [CLEN_W-1:0] clen,
                                           input logic [ADDR_W-1:0] addr);
    return {1'b0, rd, fixed, clen, addr};
  endfunction
endpackage

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
  parameter int DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wide,
  input  logic [31:0] tx,
  output logic        active,
  output logic        done,
  output logic [7:0]  rx_low,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam int HC_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [HC_W-1:0] hcnt;
  logic [5:0]      left;
  logic [31:0]     sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; done <= 1'b0; sclk <= 1'b0;
      hcnt <= '0; left <= '0; sh <= '0; rx_low <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        sh     <= tx;
        left   <= wide ? 6'd32 : 6'd8;
        hcnt   <= '0;
        sclk   <= 1'b0;
      end else if (active) begin
        if (hcnt == HC_W'(DIV - 1)) begin
          hcnt <= '0;
          if (!sclk) begin
            sclk   <= 1'b1;
            rx_low <= {rx_low[6:0], miso};
          end else begin
            sclk <= 1'b0;
            sh   <= {sh[30:0], 1'b0};
            left <= left - 6'd1;
            if (left == 6'd1) begin
              active <= 1'b0;
              done   <= 1'b1;
            end
          end
        end else begin
          hcnt <= hcnt + HC_W'(1);
        end
      end
    end
  end

  assign mosi = active & sh[31];

  // R10: the serial clock only toggles while a word is in flight
  assert_sclk_in_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sclk);
endmodule

// File: rtl/chunk_tracker.sv
module chunk_tracker
  import spice_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int MAX_CHUNK = 4092
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              ld_fixed,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              fixed,
  output logic [CLEN_W-1:0] clen,
  output logic              last
);
  localparam logic [LEN_W-1:0] MAXV = LEN_W'(MAX_CHUNK);

  logic [LEN_W-1:0] rem;

  always_comb begin
    last = (rem <= MAXV);
    clen = last ? CLEN_W'(rem) : CLEN_W'(MAXV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0; cur_addr <= '0; fixed <= 1'b0;
    end else if (load) begin
      rem <= ld_len; cur_addr <= ld_addr; fixed <= ld_fixed;
    end else if (advance) begin
      rem <= rem - LEN_W'(clen);
      if (!fixed) cur_addr <= cur_addr + ADDR_W'(clen);
    end
  end

  assert_chunk_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> (clen != '0) && (clen <= CLEN_W'(MAX_CHUNK)));
  assert_fixed_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && fixed) |=> cur_addr == $past(cur_addr));
endmodule

// File: rtl/spi_chunk_engine.sv
module spi_chunk_engine
  import spice_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int MAX_CHUNK  = 4092,
  parameter int BUSY_WORDS = 2,
  parameter int BUSY_RETRY = 1000,
  parameter int SCLK_DIV   = 2,
  parameter int CS_GAP     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_read,
  input  logic             req_fixed,
  input  logic [16:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             done,
  output logic             done_err,
  input  logic [7:0]       wr_tdata,
  input  logic             wr_tvalid,
  output logic             wr_tready,
  output logic [7:0]       rd_tdata,
  output logic             rd_tvalid,
  input  logic             rd_tready,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_cs_n
);
  localparam int BW_W = (BUSY_WORDS > 1) ? $clog2(BUSY_WORDS) : 1;
  localparam int PR_W = $clog2(BUSY_RETRY + 1);
  localparam int GP_W = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;

  eng_state_t        state, gnext;
  logic              rd_q, err;
  logic [CLEN_W-1:0] bcnt;
  logic [BW_W-1:0]   bwc;
  logic [PR_W-1:0]   pcnt;
  logic [GP_W-1:0]   gcnt;

  logic              sh_start, sh_wide, sh_active, sh_done;
  logic [31:0]       sh_tx;
  logic [7:0]        sh_rx;

  logic [ADDR_W-1:0] cur_addr;
  logic              trk_fixed, trk_last, advance, load;
  logic [CLEN_W-1:0] clen;
  logic              last_byte;

  assign load      = req_valid && (state == S_IDLE);
  assign last_byte = (bcnt == clen - CLEN_W'(1));
  assign advance   = (state == S_WDATA && sh_done && last_byte) ||
                     ((state == S_RHOLD || state == S_ZERO) && rd_tready && last_byte);

  chunk_tracker #(.LEN_W(LEN_W), .MAX_CHUNK(MAX_CHUNK)) u_trk (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(req_addr), .ld_len(req_len),
    .ld_fixed(req_fixed), .advance(advance), .cur_addr(cur_addr),
    .fixed(trk_fixed), .clen(clen), .last(trk_last));

  spi_word_shifter #(.DIV(SCLK_DIV)) u_sh (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .wide(sh_wide), .tx(sh_tx),
    .active(sh_active), .done(sh_done), .rx_low(sh_rx),
    .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso));

  always_comb begin
    sh_start = 1'b0;
    sh_wide  = 1'b1;
    sh_tx    = '0;
    unique case (state)
      S_CMD: begin
        sh_tx    = pack_cmd(rd_q, trk_fixed, clen, cur_addr);
        sh_start = !sh_active && !sh_done;
      end
      S_BUSY, S_POLL: sh_start = !sh_active && !sh_done;
      S_WDATA: begin
        sh_wide  = 1'b0;
        sh_tx    = {wr_tdata, 24'h0};
        sh_start = wr_tvalid && !sh_active && !sh_done;
      end
      S_RDATA: begin
        sh_wide  = 1'b0;
        sh_start = !sh_active && !sh_done;
      end
      default: ;
    endcase
  end

  assign wr_tready = (state == S_WDATA) && sh_start;
  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign done_err  = (state == S_DONE) && err;
  assign spi_cs_n  = !(state inside {S_CMD, S_BUSY, S_POLL, S_WDATA, S_RDATA, S_RHOLD});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; gnext <= S_IDLE; rd_q <= 1'b0; err <= 1'b0;
      bcnt <= '0; bwc <= '0; pcnt <= '0; gcnt <= '0;
      rd_tvalid <= 1'b0; rd_tdata <= '0;
    end else begin
      if (advance) begin
        gcnt  <= '0;
        gnext <= trk_last ? S_DONE : S_CMD;
        state <= S_GAP;
      end
      unique case (state)
        S_IDLE: if (req_valid) begin
          err   <= 1'b0;
          rd_q  <= req_read;
          state <= (req_len == '0) ? S_DONE : S_CMD;
        end
        S_CMD: if (sh_done) begin
          bcnt  <= '0;
          bwc   <= '0;
          state <= rd_q ? S_BUSY : S_WDATA;
        end
        S_BUSY: if (sh_done) begin
          if (bwc == BW_W'(BUSY_WORDS - 1)) begin
            pcnt  <= '0;
            gcnt  <= '0;
            gnext <= sh_rx[0] ? S_RDATA : S_POLL;
            state <= S_GAP;
          end else begin
            bwc <= bwc + BW_W'(1);
          end
        end
        S_GAP: if (gcnt == GP_W'(CS_GAP - 1)) state <= gnext;
               else gcnt <= gcnt + GP_W'(1);
        S_POLL: if (sh_done) begin
          pcnt <= pcnt + PR_W'(1);
          gcnt <= '0;
          if (sh_rx[0]) begin
            gnext <= S_RDATA;
            state <= S_GAP;
          end else if (pcnt == PR_W'(BUSY_RETRY - 1)) begin
            err       <= 1'b1;
            bcnt      <= '0;
            rd_tvalid <= 1'b1;
            rd_tdata  <= '0;
            state     <= S_ZERO;
          end else begin
            gnext <= S_POLL;
            state <= S_GAP;
          end
        end
        S_WDATA: if (sh_done && !last_byte) bcnt <= bcnt + CLEN_W'(1);
        S_RDATA: if (sh_done) begin
          rd_tdata  <= sh_rx;
          rd_tvalid <= 1'b1;
          state     <= S_RHOLD;
        end
        S_RHOLD: if (rd_tready) begin
          rd_tvalid <= 1'b0;
          if (!last_byte) begin
            bcnt  <= bcnt + CLEN_W'(1);
            state <= S_RDATA;
          end
        end
        S_ZERO: if (rd_tready) begin
          if (last_byte) rd_tvalid <= 1'b0;
          else bcnt <= bcnt + CLEN_W'(1);
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_tvalid && !rd_tready) |=> rd_tvalid && $stable(rd_tdata));
  assert_wr_handshake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tready |-> wr_tvalid);
  assert_sclk_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= PR_W'(BUSY_RETRY));
  assert_busy_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_spi_chunk_engine.sv
module sim_spi_chunk_engine;
  localparam int MAXC = 6, BW = 2, RETRY = 3, DIV = 2, GAP = 2, LW = 16;
  localparam int K_CMD = 0, K_POLL = 1, K_DATA = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0, req_fixed = 1'b0;
  logic [16:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic req_ready, done, done_err;
  logic [7:0] wr_tdata = 8'h00;
  logic wr_tvalid = 1'b0, wr_tready;
  logic [7:0] rd_tdata;
  logic rd_tvalid, rd_tready = 1'b0;
  logic spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  always #4 clk = ~clk;

  spi_chunk_engine #(.LEN_W(LW), .MAX_CHUNK(MAXC), .BUSY_WORDS(BW), .BUSY_RETRY(RETRY),
                     .SCLK_DIV(DIV), .CS_GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_fixed(req_fixed), .req_addr(req_addr), .req_len(req_len),
    .done(done), .done_err(done_err), .wr_tdata(wr_tdata), .wr_tvalid(wr_tvalid),
    .wr_tready(wr_tready), .rd_tdata(rd_tdata), .rd_tvalid(rd_tvalid), .rd_tready(rd_tready),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  int nchk = 0, nfail = 0;
  int kind = K_CMD, tbc = 0, busy_n = 0, poll_k = 0, npoll = 0, nframes = 0;
  logic [31:0] tsh = '0, tcmd = '0;
  logic [31:0] cmdlog[$];
  logic [7:0] wlog[$], wsent[$], rlog[$];
  logic wfire = 1'b0;

  function automatic logic [7:0] pat(input logic [16:0] a);
    return a[7:0] ^ a[16:9] ^ 8'hA5;
  endfunction

  function automatic logic miso_f(input int k, input int bc, input logic [31:0] c,
                                  input int bn, input int pk);
    logic [16:0] a;
    logic [7:0] d;
    if (k == K_CMD) begin
      if (bc < 32 || !c[30]) return 1'b0;
      return ((bc - 32) / 32 == BW - 1) && ((bc - 32) % 32 == 31) && (bn == 0);
    end else if (k == K_POLL) begin
      return (bc % 32 == 31) && (pk == bn);
    end
    a = c[16:0] + (c[29] ? 17'd0 : 17'(bc / 8));
    d = pat(a);
    return d[7 - bc % 8];
  endfunction

  assign spi_miso = miso_f(kind, tbc, tcmd, busy_n, poll_k);

  // target model
  always @(negedge spi_cs_n) begin tbc = 0; nframes++; end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    tsh = {tsh[30:0], spi_mosi};
    tbc++;
    if (kind == K_CMD) begin
      if (tbc == 32) tcmd = tsh;
      else if (tbc > 32 && !tcmd[30] && (tbc - 32) % 8 == 0) wlog.push_back(tsh[7:0]);
    end
  end
  always @(posedge spi_cs_n) begin
    if (kind == K_CMD) begin
      if (tbc >= 32) begin
        cmdlog.push_back(tcmd);
        if (tcmd[30]) begin
          if (busy_n == 0) kind = K_DATA;
          else begin kind = K_POLL; poll_k = 1; end
        end
      end
    end else if (kind == K_POLL) begin
      npoll++;
      if (poll_k == busy_n) kind = K_DATA;
      else if (poll_k == RETRY) kind = K_CMD;
      else poll_k++;
    end else kind = K_CMD;
  end

  // streams
  always @(posedge clk) begin
    wfire <= wr_tvalid && wr_tready;
    if (wr_tvalid && wr_tready) wsent.push_back(wr_tdata);
    if (rd_tvalid && rd_tready) rlog.push_back(rd_tdata);
  end
  always @(negedge clk) begin
    if (wfire || !wr_tvalid) begin
      wr_tvalid = ($urandom % 4 != 0);
      wr_tdata  = 8'($urandom);
    end
    rd_tready = ($urandom % 3 != 0);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input bit rd, input bit fx, input logic [16:0] a, input int len, input int bn);
    int rem, c, idx, nch, bad;
    logic [16:0] ca;
    logic [31:0] ew;
    logic [7:0] eb;
    logic err;
    busy_n = bn; npoll = 0; nframes = 0;
    cmdlog.delete(); wlog.delete(); wsent.delete(); rlog.delete();
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_fixed = fx; req_addr = a; req_len = LW'(len);
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    err = done_err;
    rem = len; ca = a; nch = 0; idx = 0; bad = 0;
    while (rem > 0) begin
      c  = (rem > MAXC) ? MAXC : rem;
      ew = {1'b0, rd, fx, 12'(c), ca};
      if (nch < cmdlog.size()) chk(cmdlog[nch] == ew, "R1 R3 command word", cmdlog[nch], ew);
      if (rd) for (int j = 0; j < c; j++) begin
        eb = (bn > RETRY) ? 8'h00 : pat(fx ? ca : ca + 17'(j));
        if (idx < rlog.size() && rlog[idx] != eb) bad++;
        idx++;
      end
      if (!fx) ca = ca + 17'(c);
      rem -= c; nch++;
    end
    chk(cmdlog.size() == nch, "R2 chunk count", cmdlog.size(), nch);
    if (len == 0) chk(nframes == 0, "R9 zero length frames", nframes, 0);
    if (rd) begin
      chk(rlog.size() == len, "R8 read byte count", rlog.size(), len);
      chk(bad == 0, (bn > RETRY) ? "R7 zero fill" : "R5 read data", bad, 0);
      chk(npoll == nch * ((bn > RETRY) ? RETRY : bn), "R6 poll count", npoll,
          nch * ((bn > RETRY) ? RETRY : bn));
      chk(err == (len > 0 && bn > RETRY), "R7 done_err", err, (len > 0 && bn > RETRY));
    end else begin
      chk(wsent.size() == len && wlog.size() == len, "R4 write byte count", wlog.size(), len);
      for (int j = 0; j < wlog.size() && j < wsent.size(); j++) if (wlog[j] != wsent[j]) bad++;
      chk(bad == 0, "R4 write data order", bad, 0);
      chk(err == 1'b0, "R7 done_err on write", err, 0);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 reset ready", req_ready, 1);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R10 reset bus idle", {spi_cs_n, spi_sclk}, 2'b10);
    chk(done == 1'b0 && rd_tvalid == 1'b0, "R9 reset outputs", {done, rd_tvalid}, 0);
    run(1'b0, 1'b0, 17'h1FFFC, 14, 0);     // R2 R3 split with address wrap
    run(1'b0, 1'b1, 17'h00123, MAXC, 0);   // R2 exactly one full chunk, fixed
    run(1'b1, 1'b1, 17'h00400, 7, 0);      // R5 ready at once, fixed address
    run(1'b1, 1'b0, 17'h00050, 13, RETRY); // R6 ready on last allowed poll
    run(1'b1, 1'b0, 17'h00900, 8, RETRY + 1); // R7 timeout
    run(1'b1, 1'b0, 17'h00010, 0, 0);      // R9 zero length
    run(1'b1, 1'b0, 17'h00200, 5, 1);      // R6 single poll
    for (int i = 0; i < 10; i++)
      run(1'($urandom % 2), ($urandom % 4 == 0), 17'($urandom), $urandom % 16, $urandom % (RETRY + 2));
    summary();
    $finish;
  end
endmodule